// File: doc/BRIEF.md
# Prioritized Interrupt Recognition Unit

This unit sits beside the retirement stage of a processor core. It chooses which pending external interrupt request, if any, the core takes at each instruction retirement boundary. Nine request sources feed it. One is a software exception signal, which stands for an exception that is already pending. The other eight are external pins. Four of those pins are captured on a rising edge and stay pending until the request is taken. Three are level requests that must still be asserted when the boundary arrives. The last is a machine-check request that is sampled only when the bus reports data ready.

Several conditions can stop a request from being taken:
- the interrupt flag,
- an NMI-in-progress block,
- a system-management-mode block,
- the machine-check enable bit,
- a one-boundary shadow after a stack-segment load,
- a write-buffer stall that affects only the sources that push state to the stack,
- a busy signal from the core.

Among the requests that are still eligible, a fixed priority picks one. The winner appears as a one-hot vector in the same cycle as the boundary strobe, and a take flag goes high with it.

A small state machine tracks the gating state. It has three states:
- `ST_OPEN`: the unit may recognize a request.
- `ST_SHADOW`: the next boundary is suppressed.
- `ST_HELD`: the core is busy.

The state machine has these transitions:
- OPEN→SHADOW on a stack-segment load.
- SHADOW→OPEN on the suppressed boundary.
- Any state →HELD while `busy_i` is high.
- HELD→OPEN on the first cycle after `busy_i` falls, or HELD→SHADOW in that cycle if a stack-segment load arrives with it.

Top module: `irq_recog`

## Requirements
- R1: `rec_o` is zero or one-hot. It is nonzero only in a cycle with `bnd_i` high. `take_o` is high exactly when `rec_o` is nonzero.
- R2: Bit positions of `rec_o`, from highest priority (bit 0) to lowest (bit 8): 0 software exception, 1 machine check, 2 halt request, 3 cache flush, 4 system-management, 5 init, 6 NMI, 7 maskable interrupt, 8 clock-stop. When several requests are eligible, the lowest bit index wins.
- R3: The cache flush, system-management, init and NMI inputs are captured on a rising edge. Each stays pending after its input drops, until it is recognized or reset.
- R4: The software exception, halt request (`halt_ni`, active low), maskable interrupt and clock-stop sources are recognized only if they are asserted during the boundary cycle.
- R5: The machine-check request is latched from `mchk_i` on every cycle with `brdy_i` high. The latched value clears when the request is recognized.
- R6: The maskable interrupt is not recognized while `if_i` is 0.
- R7: After an NMI is recognized, no further NMI is recognized until an `iret_i` pulse. A new NMI edge that arrives meanwhile stays pending.
- R8: After a system-management request is recognized, further such requests are blocked until an `smm_exit_i` pulse. Other sources are still recognized during this time.
- R9: The machine-check request is not recognized while `mce_i` is 0.
- R10: A cycle with `ss_load_i` high suppresses recognition in that cycle and at the next boundary that follows.
- R11: While `bus_busy_i` is 1 and `wbe_i` is 0, the software exception, machine check, system-management, NMI and maskable sources are ineligible. The cache flush source is also ineligible during this stall if `flush_wb_i` is 1. Lower eligible sources may win instead.
- R12: While `busy_i` is high, and in the cycle after it falls, nothing is recognized.
- R13: Reset clears all edge latches, the machine-check latch and both blocks, and leaves `rec_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bnd_i | input | 1 | Instruction retirement boundary strobe |
| ss_load_i | input | 1 | A stack-segment load has retired |
| busy_i | input | 1 | Core is servicing a non-interruptible interrupt |
| swx_i | input | 1 | Software exception pending |
| mchk_i | input | 1 | Machine-check request, sampled on bus ready |
| brdy_i | input | 1 | Bus data ready |
| halt_ni | input | 1 | Halt request, active low, level |
| cflush_i | input | 1 | Cache flush request, edge |
| smgmt_i | input | 1 | System-management request, edge |
| init_i | input | 1 | Init request, edge |
| nmi_i | input | 1 | Non-maskable interrupt, edge |
| intr_i | input | 1 | Maskable interrupt, level |
| cstop_i | input | 1 | Clock-stop request, level |
| if_i | input | 1 | Interrupt flag |
| mce_i | input | 1 | Machine-check enable |
| iret_i | input | 1 | Return from NMI handler completed |
| smm_exit_i | input | 1 | System-management mode exited |
| bus_busy_i | input | 1 | A bus cycle is in progress |
| wbe_i | input | 1 | Write buffer empty |
| flush_wb_i | input | 1 | The pending flush needs writebacks |
| rec_o | output | 9 | One-hot recognized source |
| take_o | output | 1 | A source is recognized this boundary |

## Verification
The bench builds the unit in its only configuration, the package's nine sources. At that size all 512 request combinations can be swept, each from a fresh reset. For every combination the bench works out the winner arithmetically as the lowest set bit. Directed sequences then cover each block and its release, the shadow entered both with and without a same-cycle boundary, the two write-buffer stall cases, and the busy hold together with its one-cycle tail.

// File: rtl/irq_recog_pkg.sv
package irq_recog_pkg;
    localparam int NSRC      = 9;
    localparam int NEDGE     = 4;
    localparam int S_SWX     = 0;
    localparam int S_MCHK    = 1;
    localparam int S_HALT    = 2;
    localparam int S_CFLUSH  = 3;
    localparam int S_SMGMT   = 4;
    localparam int S_INIT    = 5;
    localparam int S_NMI     = 6;
    localparam int S_INTR    = 7;
    localparam int S_CSTOP   = 8;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_SHADOW = 2'd1,
        ST_HELD   = 2'd2
    } gate_st_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_lat
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                prev_q[g] <= 1'b0;
                pend_o[g] <= 1'b0;
            end else begin
                prev_q[g] <= req_i[g];
                if (req_i[g] && !prev_q[g])
                    pend_o[g] <= 1'b1;
                else if (clr_i[g])
                    pend_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_block_unit.sv
module irq_block_unit (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic nmi_take_i,
    input  logic iret_i,
    input  logic smm_take_i,
    input  logic smm_exit_i,
    output logic nmi_blk_o,
    output logic smm_blk_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            nmi_blk_o <= 1'b0;
            smm_blk_o <= 1'b0;
        end else begin
            if (nmi_take_i)      nmi_blk_o <= 1'b1;
            else if (iret_i)     nmi_blk_o <= 1'b0;
            if (smm_take_i)      smm_blk_o <= 1'b1;
            else if (smm_exit_i) smm_blk_o <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int W = 9
) (
    input  logic [W-1:0] req_i,
    output logic [W-1:0] gnt_o
);
    logic found;

    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (req_i[i] && !found) begin
                gnt_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_recog.sv
module irq_recog
    import irq_recog_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            bnd_i,
    input  logic            ss_load_i,
    input  logic            busy_i,
    input  logic            swx_i,
    input  logic            mchk_i,
    input  logic            brdy_i,
    input  logic            halt_ni,
    input  logic            cflush_i,
    input  logic            smgmt_i,
    input  logic            init_i,
    input  logic            nmi_i,
    input  logic            intr_i,
    input  logic            cstop_i,
    input  logic            if_i,
    input  logic            mce_i,
    input  logic            iret_i,
    input  logic            smm_exit_i,
    input  logic            bus_busy_i,
    input  logic            wbe_i,
    input  logic            flush_wb_i,
    output logic [NSRC-1:0] rec_o,
    output logic            take_o
);
    gate_st_e state_q, state_d;

    logic [NEDGE-1:0] edge_req, edge_clr, edge_pend;
    logic             nmi_blk, smm_blk, mchk_q;
    logic [NSRC-1:0]  raw, stall_mask, elig, gnt;
    logic             stall, open_now;

    // Edge-captured sources, in priority order (R3)
    assign edge_req = {nmi_i, init_i, smgmt_i, cflush_i};
    assign edge_clr = {rec_o[S_NMI], rec_o[S_INIT], rec_o[S_SMGMT], rec_o[S_CFLUSH]};

    irq_edge_latch #(.W(NEDGE)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (edge_req),
        .clr_i  (edge_clr),
        .pend_o (edge_pend)
    );

    irq_block_unit u_blk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .nmi_take_i (rec_o[S_NMI]),
        .iret_i     (iret_i),
        .smm_take_i (rec_o[S_SMGMT]),
        .smm_exit_i (smm_exit_i),
        .nmi_blk_o  (nmi_blk),
        .smm_blk_o  (smm_blk)
    );

    // Machine-check request follows the bus-ready sample (R5)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               mchk_q <= 1'b0;
        else if (brdy_i)           mchk_q <= mchk_i;
        else if (rec_o[S_MCHK])    mchk_q <= 1'b0;
    end

    // Candidate requests with their own masks
    always_comb begin
        raw           = '0;
        raw[S_SWX]    = swx_i;
        raw[S_MCHK]   = mchk_q & mce_i;
        raw[S_HALT]   = ~halt_ni;
        raw[S_CFLUSH] = edge_pend[0];
        raw[S_SMGMT]  = edge_pend[1] & ~smm_blk;
        raw[S_INIT]   = edge_pend[2];
        raw[S_NMI]    = edge_pend[3] & ~nmi_blk;
        raw[S_INTR]   = intr_i & if_i;
        raw[S_CSTOP]  = cstop_i;
    end

    // Write-buffer stall applies to stack-pushing sources (R11)
    assign stall = bus_busy_i & ~wbe_i;
    always_comb begin
        stall_mask           = '0;
        stall_mask[S_SWX]    = 1'b1;
        stall_mask[S_MCHK]   = 1'b1;
        stall_mask[S_SMGMT]  = 1'b1;
        stall_mask[S_NMI]    = 1'b1;
        stall_mask[S_INTR]   = 1'b1;
        stall_mask[S_CFLUSH] = flush_wb_i;
    end
    assign elig = stall ? (raw & ~stall_mask) : raw;

    irq_prio_pick #(.W(NSRC)) u_pick (
        .req_i (elig),
        .gnt_o (gnt)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OPEN;
        else         state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (busy_i)         state_d = ST_HELD;
                else if (ss_load_i) state_d = ST_SHADOW;
            end
            ST_SHADOW: begin
                if (busy_i)         state_d = ST_HELD;
                else if (ss_load_i) state_d = ST_SHADOW;
                else if (bnd_i)     state_d = ST_OPEN;
            end
            ST_HELD: begin
                if (busy_i)         state_d = ST_HELD;
                else if (ss_load_i) state_d = ST_SHADOW;
                else                state_d = ST_OPEN;
            end
            default:                state_d = ST_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        open_now = 1'b0;
        unique case (state_q)
            ST_OPEN:   open_now = bnd_i & ~ss_load_i & ~busy_i;
            ST_SHADOW: open_now = 1'b0;
            ST_HELD:   open_now = 1'b0;
            default:   open_now = 1'b0;
        endcase
        rec_o  = open_now ? gnt : '0;
        take_o = |rec_o;
    end
endmodule

// File: rtl/irq_recog_chk.sv
module irq_recog_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       bnd_i,
    input logic       ss_load_i,
    input logic       busy_i,
    input logic       halt_ni,
    input logic       intr_i,
    input logic       if_i,
    input logic       mce_i,
    input logic       bus_busy_i,
    input logic       wbe_i,
    input logic [8:0] rec_o
);
    assert_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(rec_o));
    assert_only_on_bnd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bnd_i |-> rec_o == 9'd0);
    assert_level_halt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_ni |-> !rec_o[2]);
    assert_level_intr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !intr_i |-> !rec_o[7]);
    assert_if_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !if_i |-> !rec_o[7]);
    assert_nmi_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_o[6] |=> !rec_o[6]);
    assert_smm_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_o[4] |=> !rec_o[4]);
    assert_mce_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mce_i |-> !rec_o[1]);
    assert_shadow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ss_load_i |-> rec_o == 9'd0);
    assert_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_busy_i && !wbe_i) |-> (rec_o & 9'h0D3) == 9'd0);
    assert_busy_now_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> rec_o == 9'd0);
    assert_busy_tail_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> rec_o == 9'd0);
endmodule

bind irq_recog irq_recog_chk u_chk (.*);

// File: tb/irq_recog_bench.sv
`timescale 1ns/1ps
module irq_recog_bench;
    logic clk = 1'b0;
    logic rst_n;
    logic bnd, ss_load, busy, swx, mchk, brdy, halt_n, cflush, smgmt, init, nmi;
    logic intr, cstop, ifl, mce, iret, smm_exit, bus_busy, wbe, flush_wb;
    logic [8:0] rec;
    logic take;
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_recog u_irq_recog (
        .clk_i(clk), .rst_ni(rst_n), .bnd_i(bnd), .ss_load_i(ss_load), .busy_i(busy),
        .swx_i(swx), .mchk_i(mchk), .brdy_i(brdy), .halt_ni(halt_n), .cflush_i(cflush),
        .smgmt_i(smgmt), .init_i(init), .nmi_i(nmi), .intr_i(intr), .cstop_i(cstop),
        .if_i(ifl), .mce_i(mce), .iret_i(iret), .smm_exit_i(smm_exit),
        .bus_busy_i(bus_busy), .wbe_i(wbe), .flush_wb_i(flush_wb),
        .rec_o(rec), .take_o(take)
    );

    task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: rec_o got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        bnd = 0; ss_load = 0; busy = 0; swx = 0; mchk = 0; brdy = 0; halt_n = 1;
        cflush = 0; smgmt = 0; init = 0; nmi = 0; intr = 0; cstop = 0; ifl = 1;
        mce = 1; iret = 0; smm_exit = 0; bus_busy = 0; wbe = 1; flush_wb = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // Raise bnd at a negedge, check combinational result, then drop it
    task automatic bnd_chk(input string tag, input logic [8:0] exp);
        bnd = 1;
        #1;
        chk(tag, rec, exp);
        n_chk++;
        if (take !== (exp != 9'd0)) begin
            n_err++;
            $display("FAIL R1 take_o: got %b expected %b", take, exp != 9'd0);
        end
        @(negedge clk);
        bnd = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        do_reset();
        bnd_chk("R13 reset idle", 9'd0);

        // R2 exhaustive sweep of request combinations
        for (int p = 0; p < 512; p++) begin
            logic [8:0] pv, expv;
            pv = p[8:0];
            expv = pv & (~pv + 9'd1);
            do_reset();
            swx = pv[0]; mchk = pv[1]; brdy = pv[1]; halt_n = ~pv[2];
            cflush = pv[3]; smgmt = pv[4]; init = pv[5]; nmi = pv[6];
            intr = pv[7]; cstop = pv[8];
            @(negedge clk);
            mchk = 0; brdy = 0; cflush = 0; smgmt = 0; init = 0; nmi = 0;
            @(negedge clk);
            bnd_chk("R2 priority sweep", expv);
        end

        // R13: reset wipes pending edges
        do_reset();
        init = 1; @(negedge clk); init = 0;
        do_reset();
        bnd_chk("R13 edge cleared by reset", 9'd0);

        // R3 edge persistence and clear on recognition
        do_reset();
        init = 1; @(negedge clk); init = 0;
        repeat (3) @(negedge clk);
        bnd_chk("R3 pending init", 9'h020);
        bnd_chk("R3 init cleared", 9'd0);

        // R4 level sources
        do_reset();
        intr = 1; @(negedge clk); intr = 0;
        bnd_chk("R4 intr dropped", 9'd0);
        halt_n = 0;
        bnd_chk("R4 halt low", 9'h004);
        halt_n = 1;
        bnd_chk("R4 halt high", 9'd0);

        // R5 bus-ready sampling, R9 enable
        do_reset();
        mchk = 1; @(negedge clk); mchk = 0;
        bnd_chk("R5 no brdy", 9'd0);
        mchk = 1; brdy = 1; @(negedge clk); mchk = 0; brdy = 0;
        mce = 0;
        bnd_chk("R9 mce off", 9'd0);
        mce = 1;
        bnd_chk("R5 latched mchk", 9'h002);
        bnd_chk("R5 mchk cleared", 9'd0);

        // R6 interrupt flag
        do_reset();
        intr = 1; ifl = 0;
        bnd_chk("R6 if clear", 9'd0);
        ifl = 1;
        bnd_chk("R6 if set", 9'h080);
        intr = 0;

        // R7 NMI block
        do_reset();
        nmi = 1; @(negedge clk); nmi = 0;
        bnd_chk("R7 first nmi", 9'h040);
        nmi = 1; @(negedge clk); nmi = 0;
        bnd_chk("R7 nmi blocked", 9'd0);
        iret = 1; @(negedge clk); iret = 0;
        bnd_chk("R7 nmi after iret", 9'h040);

        // R8 SMM block
        do_reset();
        smgmt = 1; @(negedge clk); smgmt = 0;
        bnd_chk("R8 first smgmt", 9'h010);
        smgmt = 1; init = 1; @(negedge clk); smgmt = 0; init = 0;
        bnd_chk("R8 init inside smm", 9'h020);
        bnd_chk("R8 smgmt blocked", 9'd0);
        smm_exit = 1; @(negedge clk); smm_exit = 0;
        bnd_chk("R8 smgmt after exit", 9'h010);

        // R10 shadow
        do_reset();
        intr = 1;
        ss_load = 1; @(negedge clk); ss_load = 0;
        bnd_chk("R10 shadow boundary", 9'd0);
        bnd_chk("R10 after shadow", 9'h080);
        ss_load = 1;
        bnd_chk("R10 same-cycle load", 9'd0);
        ss_load = 0;
        bnd_chk("R10 next suppressed", 9'd0);
        bnd_chk("R10 reopened", 9'h080);
        intr = 0;

        // R11 write-buffer stall
        do_reset();
        intr = 1; cstop = 1; bus_busy = 1; wbe = 0;
        bnd_chk("R11 stalled intr", 9'h100);
        wbe = 1;
        bnd_chk("R11 buffer empty", 9'h080);
        intr = 0; cstop = 0;
        cflush = 1; @(negedge clk); cflush = 0;
        wbe = 0; flush_wb = 1;
        bnd_chk("R11 flush with writebacks", 9'd0);
        flush_wb = 0;
        bnd_chk("R11 flush no writebacks", 9'h008);
        bus_busy = 0; wbe = 1;

        // R12 busy hold and tail
        do_reset();
        intr = 1; busy = 1;
        bnd_chk("R12 busy", 9'd0);
        busy = 0;
        bnd_chk("R12 tail", 9'd0);
        bnd_chk("R12 released", 9'h080);
        intr = 0;

        // R1 no boundary
        intr = 1;
        #1;
        chk("R1 no boundary", rec, 9'd0);
        @(negedge clk);
        intr = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule